// File: doc/BRIEF.md
# Audio Serial Port Control and Status Registers

This block is the 32-bit memory-mapped register file of an audio serial port. It does not move any audio data on the serial lines and has no clock dividers. Software starts and stops the receiver, the transmitter and the clock generator through a write-only command word. Each engine has its own start bit and its own stop bit in that word, so software never has to read, modify and write the enables. A self-clearing soft-reset bit in the same word returns the whole block to its power-up state.

The serial datapath reports events on single-cycle strobes: a received word is ready, a transmit word was consumed, a receive overrun happened, or a transmit underrun happened. Overrun and underrun events carry a slot index. Each event sets a summary flag in the status word, and each error also sets a bit in a per-slot vector next to that flag. Software can clear status bits with a write-one-to-clear alias and force them with a write-one-to-set alias. A mask controlled through separate set and clear addresses decides which flags drive the level interrupt output. The block also holds the received word and the word to transmit, a free-form mode word for the datapath, and a read-only version constant.

Top module: `aud_csr`

## Requirements
- R1: After reset, the three run enables, the interrupt mask, the mode word and both holding words are 0. The status word reads 0x20, which means only transmit-ready is set.
- R2: The command word sits at byte offset 0x00 and reads as 0. Writing it with bit 0 set starts the receiver, bit 2 starts the clock generator and bit 4 starts the transmitter. Bit 1 stops the receiver, bit 3 stops the clock generator and bit 5 stops the transmitter. An engine whose start and stop bits are both 0 keeps its state.
- R3: When one command write sets both the start bit and the stop bit of the same engine, the engine ends up stopped.
- R4: A command write with bit 7 set returns every register and flag to its R1 value at the next clock edge. This takes priority over the other bits of that write and over any event in the same cycle.
- R5: The status word is at offset 0x08. Bit 0 shows that the receiver runs, bit 1 is receive-ready, bit 2 is receive overrun, bit 4 shows that the transmitter runs, bit 5 is transmit-ready and bit 6 is transmit underrun.
- R6: A receive strobe loads the received word into the holding register at offset 0x20 and sets receive-ready. A read of offset 0x20 returns that word and clears receive-ready. If a strobe arrives in the same cycle as the read, receive-ready stays set and holds the new word.
- R7: A write to offset 0x24 loads the transmit word output and clears transmit-ready. A consume strobe sets transmit-ready again. If the write and the consume strobe fall in the same cycle, transmit-ready ends up 0. Offset 0x24 reads as 0.
- R8: A receive overrun on slot n sets status bit 2 and bit 8+n. A transmit underrun on slot n sets status bit 6 and bit 20+n.
- R9: Writing ones to offset 0x0C clears the matching status bits among 1, 2, 5, 6, 15:8 and 27:20. The run bits 0 and 4 are not affected. When an error event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: Writing ones to offset 0x10 sets the matching status bits in the same set as R9. Bits 0 and 4 are not affected and no run enable changes.
- R11: Writing ones to offset 0x14 sets mask bits, and writing ones to offset 0x18 clears them. Only bits 1, 2, 5 and 6 can be set. The mask reads back at offset 0x1C.
- R12: The interrupt output is high exactly while some status bit among 1, 2, 5 and 6 has its mask bit set.
- R13: The mode word at offset 0x04 reads back what was written and drives the mode output. Offset 0x28 reads the version constant, whose default is 0x00000110. Offsets 0x0C, 0x10, 0x14 and 0x18 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| rx_push | input | 1 | Datapath received a word |
| rx_word | input | 32 | Received word |
| rx_ovr | input | 1 | Receive overrun strobe |
| rx_ovr_ch | input | CH_W | Slot of the overrun |
| tx_pop | input | 1 | Datapath consumed the transmit word |
| tx_udr | input | 1 | Transmit underrun strobe |
| tx_udr_ch | input | CH_W | Slot of the underrun |
| rx_run | output | 1 | Receiver enable |
| tx_run | output | 1 | Transmitter enable |
| ck_run | output | 1 | Clock generator enable |
| mode_cfg | output | 32 | Mode word for the datapath |
| tx_word | output | 32 | Word to transmit |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the checker tests the edges that follow a single stimulus. It checks that a stop bit always wins on its engine, that soft reset clears the enables and the mask, that the status bits for receive data, transmit load and error events reach the expected value one cycle later, and that the mask never holds a bit outside the interrupt sources. The bench scenarios cover what needs a history of stimulus. These are the priority of an event over a clear in the same cycle, a read and a receive strobe colliding, a transmit load colliding with a consume, the readback of every register, and the interrupt level as mask and status change in turn.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned IDX_CMD  = 0;
  localparam int unsigned IDX_MODE = 1;
  localparam int unsigned IDX_STAT = 2;
  localparam int unsigned IDX_SCLR = 3;
  localparam int unsigned IDX_SSET = 4;
  localparam int unsigned IDX_IER  = 5;
  localparam int unsigned IDX_IDR  = 6;
  localparam int unsigned IDX_IMR  = 7;
  localparam int unsigned IDX_RHR  = 8;
  localparam int unsigned IDX_THR  = 9;
  localparam int unsigned IDX_VER  = 10;

  // engine order: start bit = 2*i, stop bit = 2*i+1
  localparam int unsigned ENG_N  = 3;
  localparam int unsigned ENG_RX = 0;
  localparam int unsigned ENG_CK = 1;
  localparam int unsigned ENG_TX = 2;
  localparam int unsigned SRST_BIT = 7;

  // status bit positions
  localparam int unsigned ST_RXEN  = 0;
  localparam int unsigned ST_RXRDY = 1;
  localparam int unsigned ST_RXOVR = 2;
  localparam int unsigned ST_TXEN  = 4;
  localparam int unsigned ST_TXRDY = 5;
  localparam int unsigned ST_TXUDR = 6;
  localparam int unsigned ST_OVR_LO = 8;
  localparam int unsigned ST_UDR_LO = 20;

  localparam logic [31:0] IRQ_SRC = 32'h0000_0066;
endpackage

// File: rtl/aud_csr_en.sv
module aud_csr_en #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] en_q
);
  logic [N-1:0] en_d;
  logic         en_upd;

  for (genvar gi = 0; gi < N; gi++) begin : g_eng
    // stop bit dominates the start bit of the same engine
    assign en_d[gi] = ~srst & ~clr_v[gi] & (set_v[gi] | en_q[gi]);
  end

  assign en_upd = srst | (|set_v) | (|clr_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_upd) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/aud_csr_flags.sv
module aud_csr_flags #(
  parameter int unsigned CH_N = 8,
  localparam int unsigned CH_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srst,
  input  logic            clr_wr,
  input  logic            set_wr,
  input  logic [31:0]     wdata,
  input  logic            rx_push,
  input  logic            rhr_rd,
  input  logic            thr_wr,
  input  logic            tx_pop,
  input  logic            rx_ovr,
  input  logic [CH_W-1:0] rx_ovr_ch,
  input  logic            tx_udr,
  input  logic [CH_W-1:0] tx_udr_ch,
  output logic            rx_rdy_q,
  output logic            rx_or_q,
  output logic            tx_rdy_q,
  output logic            tx_ur_q,
  output logic [CH_N-1:0] ovr_ch_q,
  output logic [CH_N-1:0] udr_ch_q
);
  import aud_csr_pkg::*;

  logic [31:0]     clr_b, set_b;
  logic            rx_rdy_d, rx_or_d, tx_rdy_d, tx_ur_d;
  logic [CH_N-1:0] ovr_ch_d, udr_ch_d;
  logic            flag_upd;

  assign clr_b = clr_wr ? wdata : '0;
  assign set_b = set_wr ? wdata : '0;

  always_comb begin
    rx_rdy_d = rx_push | ((rx_rdy_q | set_b[ST_RXRDY]) & ~rhr_rd & ~clr_b[ST_RXRDY]);
    tx_rdy_d = ~thr_wr & (tx_pop | set_b[ST_TXRDY] | (tx_rdy_q & ~clr_b[ST_TXRDY]));
    rx_or_d  = rx_ovr | set_b[ST_RXOVR] | (rx_or_q & ~clr_b[ST_RXOVR]);
    tx_ur_d  = tx_udr | set_b[ST_TXUDR] | (tx_ur_q & ~clr_b[ST_TXUDR]);
    if (srst) begin
      rx_rdy_d = 1'b0;
      tx_rdy_d = 1'b1;
      rx_or_d  = 1'b0;
      tx_ur_d  = 1'b0;
    end
  end

  for (genvar gc = 0; gc < CH_N; gc++) begin : g_ch
    logic ovr_hit, udr_hit;
    assign ovr_hit = rx_ovr && (rx_ovr_ch == CH_W'(gc));
    assign udr_hit = tx_udr && (tx_udr_ch == CH_W'(gc));
    assign ovr_ch_d[gc] = ~srst & (ovr_hit | set_b[ST_OVR_LO+gc] |
                                   (ovr_ch_q[gc] & ~clr_b[ST_OVR_LO+gc]));
    assign udr_ch_d[gc] = ~srst & (udr_hit | set_b[ST_UDR_LO+gc] |
                                   (udr_ch_q[gc] & ~clr_b[ST_UDR_LO+gc]));
  end

  assign flag_upd = srst | clr_wr | set_wr | rx_push | rhr_rd | thr_wr |
                    tx_pop | rx_ovr | tx_udr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy_q <= 1'b0;
      rx_or_q  <= 1'b0;
      tx_rdy_q <= 1'b1;
      tx_ur_q  <= 1'b0;
      ovr_ch_q <= '0;
      udr_ch_q <= '0;
    end else if (flag_upd) begin
      rx_rdy_q <= rx_rdy_d;
      rx_or_q  <= rx_or_d;
      tx_rdy_q <= tx_rdy_d;
      tx_ur_q  <= tx_ur_d;
      ovr_ch_q <= ovr_ch_d;
      udr_ch_q <= udr_ch_d;
    end
  end
endmodule

// File: rtl/aud_csr_irq.sv
module aud_csr_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic        ier_wr,
  input  logic        idr_wr,
  input  logic [31:0] wdata,
  input  logic [31:0] stat,
  output logic [31:0] mask_q,
  output logic        irq
);
  import aud_csr_pkg::*;

  logic [31:0] mask_d;
  logic        mask_upd;

  always_comb begin
    mask_d = mask_q;
    if (ier_wr) mask_d = mask_d | (wdata & IRQ_SRC);
    if (idr_wr) mask_d = mask_d & ~wdata;
    if (srst)   mask_d = '0;
  end

  assign mask_upd = srst | ier_wr | idr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_upd) begin
      mask_q <= mask_d;
    end
  end

  assign irq = |(stat & mask_q & IRQ_SRC);
endmodule

// File: rtl/aud_csr.sv
module aud_csr #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned CH_N    = 8,
  parameter logic [31:0] VERSION = 32'h0000_0110,
  localparam int unsigned CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1,
  localparam int unsigned WIDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_push,
  input  logic [31:0]       rx_word,
  input  logic              rx_ovr,
  input  logic [CH_W-1:0]   rx_ovr_ch,
  input  logic              tx_pop,
  input  logic              tx_udr,
  input  logic [CH_W-1:0]   tx_udr_ch,
  output logic              rx_run,
  output logic              tx_run,
  output logic              ck_run,
  output logic [31:0]       mode_cfg,
  output logic [31:0]       tx_word,
  output logic              irq
);
  import aud_csr_pkg::*;

  logic [WIDX_W-1:0] widx;
  logic [31:0]       widx32;
  logic cmd_wr, mode_wr, sclr_wr, sset_wr, ier_wr, idr_wr, thr_wr, rhr_rd, srst;
  logic [ENG_N-1:0]  set_v, clr_v, en_q;
  logic rx_rdy_q, rx_or_q, tx_rdy_q, tx_ur_q;
  logic [CH_N-1:0]   ovr_ch_q, udr_ch_q;
  logic [31:0]       stat_w, imask;
  logic [31:0]       mode_q, mode_d, rxh_q, rxh_d, txh_q, txh_d;

  // address decode
  assign widx   = bus_addr[ADDR_W-1:2];
  assign widx32 = 32'(widx);
  assign cmd_wr  = bus_wr && (widx32 == IDX_CMD);
  assign mode_wr = bus_wr && (widx32 == IDX_MODE);
  assign sclr_wr = bus_wr && (widx32 == IDX_SCLR);
  assign sset_wr = bus_wr && (widx32 == IDX_SSET);
  assign ier_wr  = bus_wr && (widx32 == IDX_IER);
  assign idr_wr  = bus_wr && (widx32 == IDX_IDR);
  assign thr_wr  = bus_wr && (widx32 == IDX_THR);
  assign rhr_rd  = bus_rd && (widx32 == IDX_RHR);
  assign srst    = cmd_wr && bus_wdata[SRST_BIT];

  for (genvar ge = 0; ge < ENG_N; ge++) begin : g_cmd
    assign set_v[ge] = cmd_wr & bus_wdata[2*ge];
    assign clr_v[ge] = cmd_wr & bus_wdata[2*ge+1];
  end

  aud_csr_en #(.N(ENG_N)) u_en (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .set_v(set_v), .clr_v(clr_v), .en_q(en_q)
  );

  aud_csr_flags #(.CH_N(CH_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .clr_wr(sclr_wr), .set_wr(sset_wr), .wdata(bus_wdata),
    .rx_push(rx_push), .rhr_rd(rhr_rd), .thr_wr(thr_wr), .tx_pop(tx_pop),
    .rx_ovr(rx_ovr), .rx_ovr_ch(rx_ovr_ch), .tx_udr(tx_udr), .tx_udr_ch(tx_udr_ch),
    .rx_rdy_q(rx_rdy_q), .rx_or_q(rx_or_q), .tx_rdy_q(tx_rdy_q), .tx_ur_q(tx_ur_q),
    .ovr_ch_q(ovr_ch_q), .udr_ch_q(udr_ch_q)
  );

  always_comb begin
    stat_w = '0;
    stat_w[ST_RXEN]  = en_q[ENG_RX];
    stat_w[ST_RXRDY] = rx_rdy_q;
    stat_w[ST_RXOVR] = rx_or_q;
    stat_w[ST_TXEN]  = en_q[ENG_TX];
    stat_w[ST_TXRDY] = tx_rdy_q;
    stat_w[ST_TXUDR] = tx_ur_q;
    stat_w[ST_OVR_LO +: CH_N] = ovr_ch_q;
    stat_w[ST_UDR_LO +: CH_N] = udr_ch_q;
  end

  aud_csr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .ier_wr(ier_wr), .idr_wr(idr_wr), .wdata(bus_wdata),
    .stat(stat_w), .mask_q(imask), .irq(irq)
  );

  // data words: next state
  always_comb begin
    mode_d = mode_q;
    rxh_d  = rxh_q;
    txh_d  = txh_q;
    if (mode_wr) mode_d = bus_wdata;
    if (rx_push) rxh_d  = rx_word;
    if (thr_wr)  txh_d  = bus_wdata;
    if (srst) begin
      mode_d = '0;
      rxh_d  = '0;
      txh_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr | srst) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxh_q <= '0;
    end else if (rx_push | srst) begin
      rxh_q <= rxh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txh_q <= '0;
    end else if (thr_wr | srst) begin
      txh_q <= txh_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if      (widx32 == IDX_MODE) bus_rdata = mode_q;
      else if (widx32 == IDX_STAT) bus_rdata = stat_w;
      else if (widx32 == IDX_IMR)  bus_rdata = imask;
      else if (widx32 == IDX_RHR)  bus_rdata = rxh_q;
      else if (widx32 == IDX_VER)  bus_rdata = VERSION;
    end
  end

  assign rx_run   = en_q[ENG_RX];
  assign tx_run   = en_q[ENG_TX];
  assign ck_run   = en_q[ENG_CK];
  assign mode_cfg = mode_q;
  assign tx_word  = txh_q;
endmodule

// File: rtl/aud_csr_chk.sv
module aud_csr_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rx_push,
  input logic              rx_ovr,
  input logic [CH_W-1:0]   rx_ovr_ch,
  input logic              rx_run,
  input logic              tx_run,
  input logic              ck_run,
  input logic [31:0]       stat,
  input logic [31:0]       mask
);
  logic [ADDR_W-3:0] wi;
  logic c_wr, c_rst, t_wr;
  assign wi    = bus_addr[ADDR_W-1:2];
  assign c_wr  = bus_wr && (wi == '0);
  assign c_rst = c_wr && bus_wdata[7];
  assign t_wr  = bus_wr && (32'(wi) == 32'd9);

  // R3
  rx_stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && bus_wdata[1]) |=> !rx_run);

  // R2
  rx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && bus_wdata[0] && !bus_wdata[1] && !bus_wdata[7]) |=> rx_run);

  // R4
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_rst |=> (!rx_run && !tx_run && !ck_run && mask == 32'd0 && stat == 32'h20));

  // R6
  rx_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !c_rst) |=> stat[1]);

  // R7
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_wr) |=> !stat[5]);

  // R8
  ovr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !c_rst) |=> (stat[2] && ((stat[15:8] & (8'd1 << $past(rx_ovr_ch))) != 8'd0)));

  // R11
  mask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask & ~32'h66) == 0);
endmodule

bind aud_csr aud_csr_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rx_push(rx_push), .rx_ovr(rx_ovr),
  .rx_ovr_ch(rx_ovr_ch), .rx_run(rx_run), .tx_run(tx_run), .ck_run(ck_run),
  .stat(stat_w), .mask(imask)
);

// File: tb/sim_aud_csr.sv
`timescale 1ns/1ps
module sim_aud_csr;
  localparam int K_RD = 0, K_IRQ = 1, K_RUN = 2, K_MODE = 3, K_TXW = 4;
  localparam logic [5:0] A_CMD = 6'h00, A_MODE = 6'h04, A_STAT = 6'h08,
    A_SCLR = 6'h0C, A_SSET = 6'h10, A_IER = 6'h14, A_IDR = 6'h18,
    A_IMR = 6'h1C, A_RHR = 6'h20, A_THR = 6'h24, A_VER = 6'h28;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd, rx_push, rx_ovr, tx_pop, tx_udr;
  logic [5:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rx_word, mode_cfg, tx_word;
  logic [2:0] rx_ovr_ch, tx_udr_ch;
  logic rx_run, tx_run, ck_run, irq;

  always #4 clk = ~clk;

  aud_csr u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_word(rx_word), .rx_ovr(rx_ovr), .rx_ovr_ch(rx_ovr_ch),
    .tx_pop(tx_pop), .tx_udr(tx_udr), .tx_udr_ch(tx_udr_ch),
    .rx_run(rx_run), .tx_run(tx_run), .ck_run(ck_run),
    .mode_cfg(mode_cfg), .tx_word(tx_word), .irq(irq)
  );

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_IRQ:   act = {31'd0, irq};
        K_RUN:   act = {29'd0, ck_run, tx_run, rx_run};
        K_MODE:  act = mode_cfg;
        default: act = tx_word;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle();
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rx_push = 0; rx_word = '0; rx_ovr = 0; rx_ovr_ch = '0;
    tx_pop = 0; tx_udr = 0; tx_udr_ch = '0;
  endtask

  task automatic step();
    @(posedge clk); #2; idle();
  endtask

  task automatic expect_it(int kind, logic [31:0] e, string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step();
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    bus_rd = 1; bus_addr = a; expect_it(K_RD, e, tag); step();
  endtask

  task automatic pin(int kind, logic [31:0] e, string tag);
    expect_it(kind, e, tag); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();

    // R1 reset values
    rd(A_STAT, 32'h20, "R1 status after reset");
    rd(A_IMR, 32'h0, "R1 mask after reset");
    rd(A_MODE, 32'h0, "R1 mode after reset");
    pin(K_IRQ, 0, "R1 irq after reset");
    pin(K_RUN, 0, "R1 enables after reset");
    rd(A_VER, 32'h110, "R13 version");

    // R2 start all engines
    wr(A_CMD, 32'h15);
    pin(K_RUN, 3'b111, "R2 start all");
    rd(A_STAT, 32'h31, "R5 run mirrors in status");
    rd(A_CMD, 32'h0, "R2 command reads zero");

    // R3 stop dominance
    wr(A_CMD, 32'h03);
    pin(K_RUN, 3'b110, "R3 rx start+stop -> stopped");
    wr(A_CMD, 32'h2A);
    pin(K_RUN, 3'b000, "R2 stop all");
    wr(A_CMD, 32'h30);
    pin(K_RUN, 3'b000, "R3 tx start+stop from idle");
    wr(A_CMD, 32'h10);
    pin(K_RUN, 3'b010, "R2 tx start only");

    // R6 receive holding
    rx_push = 1; rx_word = 32'hA5A5_0001; step();
    rd(A_STAT, 32'h32, "R6 rx ready set");
    rd(A_RHR, 32'hA5A5_0001, "R6 rx word");
    rd(A_STAT, 32'h30, "R6 read clears rx ready");
    rx_push = 1; rx_word = 32'h0000_1111; step();
    bus_rd = 1; bus_addr = A_RHR; rx_push = 1; rx_word = 32'h0000_2222;
    expect_it(K_RD, 32'h0000_1111, "R6 read during push returns old word");
    step();
    rd(A_STAT, 32'h32, "R6 push beats read");
    rd(A_RHR, 32'h0000_2222, "R6 new word kept");
    rd(A_STAT, 32'h30, "R6 rx ready cleared");

    // R7 transmit holding
    wr(A_THR, 32'hCAFE_0001);
    pin(K_TXW, 32'hCAFE_0001, "R7 tx word out");
    rd(A_STAT, 32'h10, "R7 load clears tx ready");
    rd(A_THR, 32'h0, "R7 THR reads zero");
    tx_pop = 1; step();
    rd(A_STAT, 32'h30, "R7 consume sets tx ready");
    bus_wr = 1; bus_addr = A_THR; bus_wdata = 32'hCAFE_0002; tx_pop = 1; step();
    rd(A_STAT, 32'h10, "R7 load beats consume");
    pin(K_TXW, 32'hCAFE_0002, "R7 second word");
    tx_pop = 1; step();
    rd(A_STAT, 32'h30, "R7 consume again");

    // R8 error events
    rx_ovr = 1; rx_ovr_ch = 3'd3; step();
    rd(A_STAT, 32'h834, "R8 overrun slot 3");
    tx_udr = 1; tx_udr_ch = 3'd7; step();
    rd(A_STAT, 32'h0800_0874, "R8 underrun slot 7");

    // R11 / R12 mask and interrupt
    pin(K_IRQ, 0, "R12 masked off");
    wr(A_IER, 32'h04);
    rd(A_IMR, 32'h04, "R11 mask set");
    pin(K_IRQ, 1, "R12 overrun raises irq");
    wr(A_IDR, 32'h04);
    pin(K_IRQ, 0, "R12 irq drops on disable");
    wr(A_IER, 32'hFFFF_FFFF);
    rd(A_IMR, 32'h66, "R11 only source bits");
    pin(K_IRQ, 1, "R12 any source");
    rd(A_IER, 32'h0, "R13 IER reads zero");
    wr(A_IDR, 32'hFFFF_FFFF);
    rd(A_IMR, 32'h0, "R11 mask cleared");

    // R9 clear alias
    wr(A_SCLR, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h10, "R9 clear all flags, run bit kept");
    pin(K_RUN, 3'b010, "R9 enables untouched");
    bus_wr = 1; bus_addr = A_SCLR; bus_wdata = 32'h104; rx_ovr = 1; rx_ovr_ch = 3'd0; step();
    rd(A_STAT, 32'h114, "R9 event beats clear");
    wr(A_SCLR, 32'h104);
    rd(A_STAT, 32'h10, "R9 clear after event");

    // R10 set alias
    wr(A_SSET, 32'h0010_0040);
    rd(A_STAT, 32'h0010_0050, "R10 forced bits");
    wr(A_SSET, 32'h1);
    rd(A_STAT, 32'h0010_0050, "R10 run bit not settable");
    pin(K_RUN, 3'b010, "R10 enables unchanged");
    wr(A_IER, 32'h40);
    pin(K_IRQ, 1, "R12 forced underrun raises irq");

    // R13 mode word
    wr(A_MODE, 32'h1234_5678);
    rd(A_MODE, 32'h1234_5678, "R13 mode readback");
    pin(K_MODE, 32'h1234_5678, "R13 mode output");

    // R4 soft reset wins over start bit
    wr(A_CMD, 32'h81);
    pin(K_RUN, 0, "R4 enables cleared");
    rd(A_STAT, 32'h20, "R4 status reset");
    rd(A_IMR, 32'h0, "R4 mask reset");
    rd(A_MODE, 32'h0, "R4 mode reset");
    pin(K_IRQ, 0, "R4 irq low");
    pin(K_TXW, 32'h0, "R4 tx word reset");

    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule